// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block is the target (slave) side of a two-wire I2C bus, meant to sit next to a local processor. It samples the open-drain SCL and SDA lines through a synchronizer and finds START and STOP conditions. After a START it shifts in the address byte and compares the upper seven bits with a programmable own address. If general-call recognition is switched on, it also compares them with the general-call address 0x00. When the address matches, the block acknowledges it. It then either delivers received bytes to the processor or takes bytes from the processor and shifts them out.

Received bytes leave the block on a valid/ready stream, and bytes to transmit enter it on a second valid/ready stream. The bus itself applies the back-pressure. While the block waits for the processor on either stream, it holds SCL low, which stalls the bus master until the handshake completes. `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is sampled high. `tx_ready` stays high until `tx_valid` is sampled high, and `tx_data` is taken on that same edge. Neither stream may be driven ahead of the bus: a byte is offered or requested only at the matching point of the transfer. Control inputs and status outputs are plain level signals.

Top module: `i2ct_target`

## Requirements
- R1: After reset both line enables (`scl_oe`, `sda_oe`) are 0, `busy`, `rx_valid`, `tx_ready`, `addr_hit`, `gc_hit` and `irq` are 0. A 1 on an enable pulls that line low; a 0 releases it to the external pull-up.
- R2: `busy` goes high when a START (SDA falling while SCL is high) is seen and goes low when a STOP (SDA rising while SCL is high) is seen. `stop_evt` pulses for one cycle in the same cycle that `busy` falls.
- R3: When `en` and `ack_en` are 1 and address-byte bits 7..1 equal `own_addr`, the block pulls SDA low during the ninth clock. It sets `addr_hit` until the next START or STOP, and sets `slave_tx` to bit 0 of the address byte (1 = the target transmits).
- R4: Address 0x00 is acknowledged, and `gc_hit` is set, only when `gc_en` is 1. With `gc_en` at 0 it is not acknowledged.
- R5: A non-matching address, or any address while `ack_en` is 0, leaves SDA released during the ninth clock. The block then ignores the bus until the next START or STOP.
- R6: In a write transfer the block samples eight data bits MSB first on SCL rising edges. From the SCL falling edge after the eighth bit it holds SCL low and `rx_valid` high, with `rx_data` stable, until `rx_ready` is sampled high.
- R7: After the receive handshake the block releases SCL and pulls SDA low during the ninth clock if `ack_en` was 1 at the handshake. Otherwise it leaves SDA released (NACK).
- R8: In a read transfer, after the address acknowledge and after every master ACK, the block holds SCL low with `tx_ready` high until `tx_valid`. It then shifts the byte out MSB first, changing SDA only while SCL is low.
- R9: A master NACK (SDA high in the ninth clock) after a transmitted byte ends the transfer. SDA is released and no further `tx_ready` appears until a new START.
- R10: A repeated START in the middle of a transfer restarts the address phase, and the new address and direction take effect.
- R11: With `en` at 0 the block returns to idle on the next cycle, releases both lines and does not respond to any address.
- R12: `irq` is high while `rx_valid` or `tx_ready` is high, for one cycle on an address match, and for one cycle on `stop_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable |
| ack_en | input | 1 | Acknowledge generation enable |
| gc_en | input | 1 | General-call recognition enable |
| own_addr | input | 7 | Own 7-bit bus address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Processor accepts received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Processor offers byte to transmit |
| tx_ready | output | 1 | Block requests byte to transmit |
| tx_data | input | 8 | Byte to transmit |
| addr_hit | output | 1 | Own or general-call address acknowledged |
| gc_hit | output | 1 | The match was the general-call address |
| slave_tx | output | 1 | Direction of current transfer, 1 = target transmits |
| stop_evt | output | 1 | One-cycle pulse on STOP |
| busy | output | 1 | Between START and STOP |
| irq | output | 1 | Processor attention request |

## Verification
The hardest situations to reach from the ports are those where the bus ends or restarts a transfer while the block is mid-byte or stretching. These are a master NACK after a transmitted byte, a repeated START straight after a received byte, and `en` being dropped while SCL is held low waiting for `tx_valid`. The bench drives SCL and SDA bit by bit from a master model that honours stretching, so it can place a NACK, a repeated START or a STOP at any bit. A processor model with an adjustable response delay keeps the block waiting long enough for the stretch to be measured and for `en` to be changed mid-wait.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RXB,
    ST_RXH,
    ST_RXA,
    ST_TXH,
    ST_TXB,
    ST_TXA,
    ST_WAIT
  } tstate_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '1;
        else if (g == 0) pipe[g] <= d;
        else pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_linemon.sv
module i2ct_linemon (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = !scl_p && scl_s;
  assign scl_fall  = scl_p && !scl_s;
  // SDA may only move during SCL high for a bus condition
  assign start_det = scl_p && scl_s && sda_p && !sda_s;
  assign stop_det  = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              addr_hit,
  output logic              gc_hit,
  output logic              slave_tx,
  output logic              addr_evt,
  output logic              stop_evt,
  output logic              busy
);
  tstate_e           state;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              ack_q, mnack;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic own_m, gc_m;
  assign own_m = (sh[BYTE_W-1:1] == own_addr);
  assign gc_m  = gc_en && (sh[BYTE_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sh       <= '0;
      cnt      <= '0;
      ack_q    <= 1'b0;
      mnack    <= 1'b0;
      slave_tx <= 1'b0;
      addr_hit <= 1'b0;
      gc_hit   <= 1'b0;
      addr_evt <= 1'b0;
      stop_evt <= 1'b0;
    end else begin
      addr_evt <= 1'b0;
      stop_evt <= 1'b0;
      if (!en) begin
        state    <= ST_IDLE;
        addr_hit <= 1'b0;
        gc_hit   <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        addr_hit <= 1'b0;
        gc_hit   <= 1'b0;
        stop_evt <= (state != ST_IDLE);
      end else if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        addr_hit <= 1'b0;
        gc_hit   <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RXB: begin
            if (scl_rise && cnt != LAST) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (state == ST_RXB) state <= ST_RXH;
              else if (ack_en && (own_m || gc_m)) begin
                state    <= ST_AACK;
                addr_hit <= 1'b1;
                gc_hit   <= gc_m;
                slave_tx <= sh[0];
                addr_evt <= 1'b1;
              end else state <= ST_WAIT;
            end
          end
          ST_AACK: if (scl_fall) begin
            state <= slave_tx ? ST_TXH : ST_RXB;
            cnt   <= '0;
          end
          ST_RXH: if (rx_ready) begin
            state <= ST_RXA;
            ack_q <= ack_en;
          end
          ST_RXA: if (scl_fall) begin
            state <= ST_RXB;
            cnt   <= '0;
          end
          ST_TXH: if (tx_valid) begin
            sh    <= tx_data;
            cnt   <= '0;
            state <= ST_TXB;
          end
          ST_TXB: begin
            if (scl_rise && cnt != LAST) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == LAST) state <= ST_TXA;
              else sh <= {sh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TXA: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) state <= mnack ? ST_WAIT : ST_TXH;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_AACK: sda_oe = 1'b1;
      ST_RXA:  sda_oe = ack_q;
      ST_TXB:  sda_oe = !sh[BYTE_W-1];
      default: sda_oe = 1'b0;
    endcase
  end

  assign rx_valid = (state == ST_RXH);
  assign tx_ready = (state == ST_TXH);
  assign scl_oe   = rx_valid || tx_ready;
  assign rx_data  = sh;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              addr_hit,
  output logic              gc_hit,
  output logic              slave_tx,
  output logic              stop_evt,
  output logic              busy,
  output logic              irq
);
  logic [1:0] lines_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, addr_evt;

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2ct_linemon u_mon (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_engine u_eng (
    .clk(clk), .rst(rst), .en(en), .ack_en(ack_en), .gc_en(gc_en),
    .own_addr(own_addr), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .addr_hit(addr_hit),
    .gc_hit(gc_hit), .slave_tx(slave_tx), .addr_evt(addr_evt),
    .stop_evt(stop_evt), .busy(busy)
  );

  assign irq = rx_valid || tx_ready || addr_evt || stop_evt;
endmodule

// File: rtl/i2ct_target_chk.sv
module i2ct_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       scl_s,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       addr_hit,
  input logic       stop_evt,
  input logic       busy
);
  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (en && rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_rx_release_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> (!rx_valid && !scl_oe));

  assert_tx_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (en && tx_ready && !tx_valid) |=> tx_ready);

  assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !$stable(sda_oe)) |-> !scl_s);

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    stop_evt |-> !busy);

  assert_disable_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && !scl_oe && !sda_oe));

  assert_hit_busy_R3: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> busy);
endmodule

bind i2ct_target i2ct_target_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .scl_s(scl_s), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .addr_hit(addr_hit), .stop_evt(stop_evt), .busy(busy)
);

// File: tb/i2ct_target_tb.sv
`timescale 1ns/1ps
module i2ct_target_tb;
  localparam int HALF = 25;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en, ack_en, gc_en;
  logic scl_oe, sda_oe, rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;
  logic addr_hit, gc_hit, slave_tx, stop_evt, busy, irq;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  wire scl_line = !(scl_oe || m_scl_low);
  wire sda_line = !(sda_oe || m_sda_low);

  i2ct_target u_dut (
    .clk(clk), .rst(rst), .en(en), .ack_en(ack_en), .gc_en(gc_en),
    .own_addr(OWN), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .addr_hit(addr_hit), .gc_hit(gc_hit),
    .slave_tx(slave_tx), .stop_evt(stop_evt), .busy(busy), .irq(irq)
  );

  int checks = 0, errors = 0;
  int sw_wait = 4, wait_cnt = 0, hold_cycles = 0, irq_miss = 0, rx_cnt = 0;
  int stop_pulses = 0;
  logic [7:0] rx_got = '0;
  logic [7:0] tx_q [4];
  logic [1:0] tx_idx = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // processor model: answers both streams after sw_wait cycles
  initial begin
    tx_valid = 1'b0; rx_ready = 1'b0; tx_data = '0;
    forever begin
      @(negedge clk);
      if (stop_evt) stop_pulses++;
      if (tx_valid && !tx_ready) tx_valid = 1'b0;
      if (rx_ready && !rx_valid) rx_ready = 1'b0;
      if ((tx_ready && !tx_valid) || (rx_valid && !rx_ready)) begin
        if (!scl_line) hold_cycles++;
        if (!irq) irq_miss++;
        wait_cnt++;
        if (wait_cnt >= sw_wait) begin
          wait_cnt = 0;
          if (tx_ready) begin
            tx_data = tx_q[tx_idx]; tx_idx++; tx_valid = 1'b1;
          end else begin
            rx_got = rx_data; rx_cnt++; rx_ready = 1'b1;
          end
        end
      end else wait_cnt = 0;
    end
  end

  task automatic hclk(); repeat (HALF) @(negedge clk); endtask
  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask
  task automatic bus_start();
    m_sda_low = 1'b0; hclk(); scl_up(); hclk();
    m_sda_low = 1'b1; hclk(); m_scl_low = 1'b1; hclk();
  endtask
  task automatic bus_stop();
    m_sda_low = 1'b1; hclk(); scl_up(); hclk(); m_sda_low = 1'b0; hclk();
  endtask
  task automatic wr_bit(input logic b);
    m_sda_low = !b; hclk(); scl_up(); hclk(); m_scl_low = 1'b1;
  endtask
  task automatic rd_bit(output logic b);
    m_sda_low = 1'b0; hclk(); scl_up(); b = sda_line; hclk(); m_scl_low = 1'b1;
  endtask
  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(b); ack = !b;
  endtask
  task automatic rd_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); v[i] = b; end
    wr_bit(!ack);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  // {ack_en, gc_en, exp_ack, rw, addr[6:0], data[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 7'h3A, 8'hA5},
    {1'b1, 1'b0, 1'b1, 1'b1, 7'h3A, 8'h5C},
    {1'b1, 1'b0, 1'b0, 1'b0, 7'h3B, 8'h11},
    {1'b1, 1'b0, 1'b0, 1'b0, 7'h00, 8'h22},
    {1'b1, 1'b1, 1'b1, 1'b0, 7'h00, 8'h81},
    {1'b0, 1'b0, 1'b0, 1'b0, 7'h3A, 8'h33},
    {1'b1, 1'b0, 1'b1, 1'b1, 7'h3A, 8'hFF},
    {1'b1, 1'b1, 1'b1, 1'b0, 7'h3A, 8'h00}
  };

  initial begin
    logic ack;
    logic [7:0] v;
    int n0;
    rst = 1'b1; en = 1'b1; ack_en = 1'b1; gc_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 line enables", {scl_oe, sda_oe}, 2'b00);
    chk("R1 flags", {busy, rx_valid, tx_ready, addr_hit, gc_hit}, 5'b0);
    chk("R12 irq idle", irq, 1'b0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 after reset", {busy, scl_oe, sda_oe, irq}, 4'b0);

    foreach (VEC[k]) begin
      ack_en = VEC[k][18]; gc_en = VEC[k][17];
      tx_q[0] = VEC[k][7:0]; tx_idx = '0; sw_wait = 4;
      n0 = rx_cnt;
      bus_start();
      chk("R2 busy after START", busy, 1'b1);
      wr_byte({VEC[k][14:8], VEC[k][15]}, ack);
      chk($sformatf("R3 R4 R5 address ack vec%0d", k), ack, VEC[k][16]);
      if (VEC[k][16]) begin
        chk("R3 addr_hit", addr_hit, 1'b1);
        chk("R4 gc_hit", gc_hit, (VEC[k][14:8] == 7'h00));
        chk("R3 direction", slave_tx, VEC[k][15]);
        if (VEC[k][15]) begin
          rd_byte(v, 1'b0);
          chk($sformatf("R8 read data vec%0d", k), v, VEC[k][7:0]);
        end else begin
          wr_byte(VEC[k][7:0], ack);
          chk($sformatf("R6 rx data vec%0d", k), rx_got, VEC[k][7:0]);
          chk("R7 data ack", ack, 1'b1);
        end
      end else begin
        wr_byte(8'h5A, ack);
        chk("R5 later byte ignored", {ack, 32'(rx_cnt - n0)}, 33'b0);
      end
      n0 = stop_pulses;
      bus_stop();
      repeat (8) @(negedge clk);
      chk("R2 idle after STOP", {busy, addr_hit}, 2'b00);
      chk("R2 one stop pulse", stop_pulses - n0, 1);
    end

    // receive stretch
    ack_en = 1'b1; gc_en = 1'b0; sw_wait = 150;
    bus_start(); wr_byte({OWN, 1'b0}, ack);
    hold_cycles = 0; irq_miss = 0;
    wr_byte(8'hC3, ack);
    chk("R6 SCL held while rx waits", hold_cycles >= 100, 1'b1);
    chk("R6 stretched data", rx_got, 8'hC3);
    chk("R12 irq while rx waits", irq_miss, 0);
    // ack disabled for next byte, then repeated START into a read
    ack_en = 1'b0; sw_wait = 4;
    wr_byte(8'h3C, ack);
    chk("R7 NACK when ack disabled", ack, 1'b0);
    chk("R7 byte still delivered", rx_got, 8'h3C);
    ack_en = 1'b1;
    tx_q[0] = 8'h96; tx_q[1] = 8'h69; tx_idx = '0; sw_wait = 150;
    bus_start(); wr_byte({OWN, 1'b1}, ack);
    chk("R10 repeated START read acked", {ack, slave_tx}, 2'b11);
    hold_cycles = 0; irq_miss = 0;
    rd_byte(v, 1'b1);
    chk("R8 first byte", v, 8'h96);
    chk("R8 SCL held while tx waits", hold_cycles >= 100, 1'b1);
    chk("R12 irq while tx waits", irq_miss, 0);
    sw_wait = 4;
    rd_byte(v, 1'b0);
    chk("R8 second byte after ACK", v, 8'h69);
    repeat (3 * HALF) @(negedge clk);
    chk("R9 released after master NACK", {tx_ready, sda_oe, scl_oe, busy}, 4'b0001);
    bus_stop();
    repeat (8) @(negedge clk);

    // drop enable while stretching for transmit data
    sw_wait = 400; tx_idx = '0;
    bus_start(); wr_byte({OWN, 1'b1}, ack);
    repeat (20) @(negedge clk);
    chk("R8 waiting for tx data", {tx_ready, scl_oe}, 2'b11);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 disable releases", {busy, scl_oe, sda_oe, tx_ready}, 4'b0);
    bus_stop();
    sw_wait = 4;
    bus_start(); wr_byte({OWN, 1'b0}, ack);
    chk("R11 disabled ignores address", {ack, busy}, 2'b00);
    bus_stop();
    en = 1'b1;
    repeat (8) @(negedge clk);
    summary();
  end
endmodule